// File: doc/BRIEF.md
# Oscillator Control and Status Register

This block is the software-visible control and status word of a clock-switching unit. Firmware writes it to pick the next oscillator source and to ask for a switch. It also turns the low-power secondary oscillator on or off. Reading it shows whether the PLL is locked and whether the fail-safe monitor has seen a clock failure.

Most status bits change because of hardware events, not only because of bus writes. The clock-switch sequencer sends one-cycle strobes when a switch starts, when it completes, when the requested source equals the current one (a redundant switch), and when the monitor forces a fallback to the internal fast RC oscillator. The PLL sends strobes for start, lock and loss of lock. The fail-safe monitor sends a clock-fail pulse.

A level input says whether the PLL is the selected system clock. The LOCK bit is masked with it on every read.

All state is cleared by the combined power-on/brown-out reset. A write lands at the clock edge, and the read word is combinational from the registered state.

Top module: `osc_ctl_reg`

## Requirements
- R1: While reset is asserted and right after it is released, `rdata` reads 0x0000.
- R2: The read word is laid out as follows: switch request at bit 0, secondary oscillator enable at bit 1, clock-fail at bit 3, PLL lock at bit 5, next-source field at bits 10:8. Every other bit reads 0.
- R3: A write stores `wdata[1]` as the secondary oscillator enable and `wdata[10:8]` as the next-source field. Both read back unchanged from the cycle after the write.
- R4: A write with `wdata[0]`=1 sets the switch request. A write with `wdata[0]`=0 leaves it unchanged.
- R5: A switch-done, redundant-switch or fallback strobe clears the switch request in the next cycle. If a write with `wdata[0]`=1 arrives in the same cycle, the request stays 1.
- R6: A pll_lock strobe sets LOCK only after a pll_start strobe has been seen since the last reset or switch start. Without such an arming pll_start, pll_lock has no effect.
- R7: A pll_unlock strobe clears LOCK. A sw_start strobe clears LOCK and also disarms it, so a later pll_lock needs a new pll_start.
- R8: Bit 5 reads 0 whenever `pll_selected` is low. The stored lock state is kept and reappears when `pll_selected` rises again.
- R9: A cf_detect pulse sets the clock-fail bit, which then stays set. A write with `wdata[3]`=1 and writes to bit 5 have no effect on the stored bits.
- R10: The clock-fail bit is cleared by a write with `wdata[3]`=0 or by a sw_start strobe. If a cf_detect pulse arrives in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Power-on/brown-out reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe for the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, masked status word |
| sw_start | input | 1 | Sequencer: valid switch sequence started |
| sw_done | input | 1 | Sequencer: switch completed |
| sw_redundant | input | 1 | Sequencer: request named the current source |
| sw_fallback | input | 1 | Monitor forced fallback to internal fast RC |
| pll_start | input | 1 | PLL started, arms lock capture |
| pll_lock | input | 1 | PLL reports lock |
| pll_unlock | input | 1 | PLL reports loss of lock |
| cf_detect | input | 1 | Fail-safe monitor detected clock failure |
| pll_selected | input | 1 | PLL is the current system clock |

## Verification
The hardest cases to reach from the ports are the ones where hardware events and bus writes hit the same bit in the same cycle. Examples are a failure pulse together with a software clear, and a completion strobe together with a new request. A masked lock that has to survive while the PLL is deselected is just as hard. The vector table drives each of these coincidences on purpose at a chosen step. The lock arming sequence is walked in order: lock without start, start, lock, deselect, reselect, unlock, and switch start. A randomized stretch then drives sparse strobes and writes against a bench-side model, so that other overlaps also occur.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned SRC_W   = 3;
  localparam int unsigned B_REQ   = 0;
  localparam int unsigned B_LPEN  = 1;
  localparam int unsigned B_CF    = 3;
  localparam int unsigned B_LOCK  = 5;
  localparam int unsigned B_SRC   = 8;

  typedef struct packed {
    logic             req;
    logic             lpen;
    logic             cf;
    logic             lock;
    logic [SRC_W-1:0] src;
  } osc_state_t;

  function automatic logic [WORD_W-1:0] pack_word(input osc_state_t s, input logic sel);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_REQ]  = s.req;
    w[B_LPEN] = s.lpen;
    w[B_CF]   = s.cf;
    w[B_LOCK] = s.lock & sel;
    w[B_SRC +: SRC_W] = s.src;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] live_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[B_REQ] = 1'b1; m[B_LPEN] = 1'b1; m[B_CF] = 1'b1; m[B_LOCK] = 1'b1;
    m[B_SRC +: SRC_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/osc_lock_track.sv
module osc_lock_track (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_start,
  input  logic pll_start,
  input  logic pll_lock,
  input  logic pll_unlock,
  output logic lock_q
);
  logic armed_q;
  logic lock_set, lock_clr;

  assign lock_set = pll_lock & armed_q;
  assign lock_clr = pll_unlock | sw_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      if (pll_start)     armed_q <= 1'b1;
      else if (sw_start) armed_q <= 1'b0;
      if (lock_clr)      lock_q <= 1'b0;
      else if (lock_set) lock_q <= 1'b1;
    end
  end

  // R7
  lock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_start || pll_unlock) |=> !lock_q);
  // R6
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_lock && armed_q && !pll_unlock && !sw_start) |=> lock_q);
endmodule

// File: rtl/osc_fail_flag.sv
module osc_fail_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cf_detect,
  input  logic sw_start,
  input  logic sw_clr,
  output logic cf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cf_q <= 1'b0;
    else if (cf_detect)         cf_q <= 1'b1;
    else if (sw_clr | sw_start) cf_q <= 1'b0;
  end

  // R10
  cf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cf_detect |=> cf_q);
  // R9
  cf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_q && !sw_start && !sw_clr) |=> cf_q);
endmodule

// File: rtl/osc_switch_req.sv
module osc_switch_req #(
  parameter int unsigned SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_req,
  input  logic             wr_lpen,
  input  logic [SRC_W-1:0] wr_src,
  input  logic             hw_clr,
  output logic             req_q,
  output logic             lpen_q,
  output logic [SRC_W-1:0] src_q
);
  logic wr_set;
  assign wr_set = wr_en & wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      lpen_q <= 1'b0;
      src_q  <= '0;
    end else begin
      if (wr_set)      req_q <= 1'b1;
      else if (hw_clr) req_q <= 1'b0;
      if (wr_en) begin
        lpen_q <= wr_lpen;
        src_q  <= wr_src;
      end
    end
  end

  // R5
  req_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr && !wr_set) |=> !req_q);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !hw_clr) |=> req_q);
endmodule

// File: rtl/osc_ctl_reg.sv
module osc_ctl_reg
  import osc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              sw_start,
  input  logic              sw_done,
  input  logic              sw_redundant,
  input  logic              sw_fallback,
  input  logic              pll_start,
  input  logic              pll_lock,
  input  logic              pll_unlock,
  input  logic              cf_detect,
  input  logic              pll_selected
);
  osc_state_t st;
  logic       req_hw_clr;
  logic       cf_sw_clr;

  assign req_hw_clr = sw_done | sw_redundant | sw_fallback;
  assign cf_sw_clr  = wr_en & ~wdata[B_CF];

  osc_switch_req #(.SRC_W(SRC_W)) u_req (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_req(wdata[B_REQ]), .wr_lpen(wdata[B_LPEN]),
    .wr_src(wdata[B_SRC +: SRC_W]), .hw_clr(req_hw_clr),
    .req_q(st.req), .lpen_q(st.lpen), .src_q(st.src)
  );

  osc_lock_track u_lock (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start),
    .pll_start(pll_start), .pll_lock(pll_lock), .pll_unlock(pll_unlock),
    .lock_q(st.lock)
  );

  osc_fail_flag u_cf (
    .clk(clk), .rst_n(rst_n), .cf_detect(cf_detect),
    .sw_start(sw_start), .sw_clr(cf_sw_clr), .cf_q(st.cf)
  );

  assign rdata = pack_word(st, pll_selected);

  // R8
  lock_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_selected |-> !rdata[B_LOCK]);
  // R2
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~live_mask()) == '0);
  // R3
  lpen_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[B_LPEN] == $past(wdata[B_LPEN])));
endmodule

// File: tb/osc_ctl_reg_test.sv
module osc_ctl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  ev = '0;
  logic        sel = 1'b1;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  osc_ctl_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .sw_start(ev[0]), .sw_done(ev[1]), .sw_redundant(ev[2]), .sw_fallback(ev[3]),
    .pll_start(ev[4]), .pll_lock(ev[5]), .pll_unlock(ev[6]), .cf_detect(ev[7]),
    .pll_selected(sel)
  );

  // {events, wr, wdata, pll_selected, expected}
  localparam logic [41:0] VEC [28] = '{
    {8'h00,1'b1,16'h0102,1'b1,16'h0102}, // R3
    {8'h00,1'b1,16'h0103,1'b1,16'h0103}, // R4 set
    {8'h00,1'b1,16'h0002,1'b1,16'h0003}, // R4 write 0 ignored
    {8'h02,1'b0,16'h0000,1'b1,16'h0002}, // R5 done
    {8'h00,1'b1,16'h0301,1'b1,16'h0301},
    {8'h04,1'b0,16'h0000,1'b1,16'h0300}, // R5 redundant
    {8'h00,1'b1,16'h0301,1'b1,16'h0301},
    {8'h08,1'b0,16'h0000,1'b1,16'h0300}, // R5 fallback
    {8'h02,1'b1,16'h0301,1'b1,16'h0301}, // R5 write wins
    {8'h02,1'b0,16'h0000,1'b1,16'h0300},
    {8'h20,1'b0,16'h0000,1'b1,16'h0300}, // R6 unarmed
    {8'h10,1'b0,16'h0000,1'b1,16'h0300},
    {8'h20,1'b0,16'h0000,1'b1,16'h0320}, // R6 armed
    {8'h00,1'b0,16'h0000,1'b0,16'h0300}, // R8 masked
    {8'h00,1'b0,16'h0000,1'b1,16'h0320}, // R8 reappears
    {8'h40,1'b0,16'h0000,1'b1,16'h0300}, // R7 unlock
    {8'h20,1'b0,16'h0000,1'b1,16'h0320},
    {8'h01,1'b0,16'h0000,1'b1,16'h0300}, // R7 sw_start
    {8'h20,1'b0,16'h0000,1'b1,16'h0300}, // R7 disarmed
    {8'h80,1'b0,16'h0000,1'b1,16'h0308}, // R9 set
    {8'h00,1'b1,16'h0308,1'b1,16'h0308}, // R9 write 1 no effect
    {8'h00,1'b0,16'h0000,1'b1,16'h0308}, // R9 sticky
    {8'h00,1'b1,16'h0300,1'b1,16'h0300}, // R10 sw clear
    {8'h80,1'b1,16'h0300,1'b1,16'h0308}, // R10 set wins
    {8'h01,1'b0,16'h0000,1'b1,16'h0300}, // R10 sw_start clear
    {8'h81,1'b0,16'h0000,1'b1,16'h0308}, // R10 set wins over sw_start
    {8'h00,1'b1,16'hFFFF,1'b1,16'h070B}, // R2 unimplemented zero
    {8'h00,1'b1,16'h0000,1'b1,16'h0001}  // R2 R10
  };

  task automatic check(input string req, input logic [15:0] exp);
    n_run++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
    end
  endtask

  task automatic step(input logic [7:0] e, input logic w, input logic [15:0] d, input logic s);
    @(negedge clk);
    ev = e; wr_en = w; wdata = d; sel = s;
    @(posedge clk);
    #2;
    ev = '0; wr_en = 1'b0;
  endtask

  logic m_req, m_lp, m_cf, m_lock, m_arm;
  logic [2:0] m_src;

  function automatic logic [15:0] model_word(input logic s);
    return {5'b0, m_src, 2'b0, m_lock & s, 1'b0, m_cf, 1'b0, m_lp, m_req};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R1 in reset", 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R1 after release", 16'h0000);

    foreach (VEC[i]) begin
      step(VEC[i][41:34], VEC[i][33], VEC[i][32:17], VEC[i][16]);
      check($sformatf("vector %0d", i), VEC[i][15:0]);
    end

    // R1: reset mid-operation clears everything
    @(negedge clk); rst_n = 1'b0;
    #1 check("R1 async reset", 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // randomized run against bench model (R3-R10)
    m_req = 0; m_lp = 0; m_cf = 0; m_lock = 0; m_arm = 0; m_src = 0;
    for (int k = 0; k < 400; k++) begin
      logic [7:0] e; logic w; logic [15:0] d; logic s;
      e = '0;
      for (int b = 0; b < 8; b++) e[b] = ($urandom_range(0, 5) == 0);
      w = ($urandom_range(0, 3) == 0);
      d = 16'($urandom);
      s = ($urandom_range(0, 4) != 0);
      step(e, w, d, s);
      begin
        logic n_req, n_cf, n_lock, n_arm;
        n_req = m_req; n_cf = m_cf; n_lock = m_lock; n_arm = m_arm;
        if (e[1] || e[2] || e[3]) n_req = 0;
        if (w && d[0]) n_req = 1;
        if (w) begin m_lp = d[1]; m_src = d[10:8]; end
        if (e[0] || (w && !d[3])) n_cf = 0;
        if (e[7]) n_cf = 1;
        if (e[5] && m_arm) n_lock = 1;
        if (e[6] || e[0]) n_lock = 0;
        if (e[0]) n_arm = 0;
        if (e[4]) n_arm = 1;
        m_req = n_req; m_cf = n_cf; m_lock = n_lock; m_arm = n_arm;
      end
      check($sformatf("random %0d (R3-R10 model)", k), model_word(s));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule